// File: doc/BRIEF.md
# DMA Page Translation Table

This block maps I/O bus addresses onto physical memory pages through a table of 64-bit translation entries held on chip. Each entry stores a page-aligned physical address. Its two lowest bits give the access rights for that page. A device-side lookup port takes a bus address. One cycle later it returns the translated page address, the page-aligned I/O address, the in-page offset mask and the permission.

A control side manages the table. A configuration port turns the table on with a page shift, a bus offset and an entry count, or turns it off. A clear pulse wipes every entry to no-access. An operation port performs single-entry put (write) and get (read). Each successful put raises a one-cycle invalidation notice that carries the new mapping, so that caches downstream can drop stale translations.

Top module: `dma_xlate_table`

## Requirements
- R1: The lookup permission output copies entry bits [1:0]: 0 means no access, 1 means read only, 2 means write only and 3 means read and write.
- R2: A lookup is accepted when `lk_valid` and `lk_ready` are both high. One cycle after acceptance, `lk_rsp_valid` is high. For an index `addr >> shift` below the entry count, the outputs are:
  - `lk_rsp_paddr` = entry AND page mask;
  - `lk_rsp_iova` = addr AND page mask;
  - `lk_rsp_mask` = NOT page mask.

  The page mask has its low `shift` bits clear.
- R3: A lookup whose index is not below the entry count returns paddr 0, iova 0, an all-ones mask and permission 0. This includes every lookup while the table is disabled.
- R4: A put aligns `op_ioba` down to the page and forms index = (aligned − offset) >> shift. When the index is below the entry count, the put stores `op_data` and pulses `op_done` one cycle later with `op_status` = 0.
- R5: A put or get whose index is not below the entry count, including an ioba below the offset, reports `op_status` = 1 with `op_rdata` = 0. Such a put leaves the table unchanged.
- R6: A get with a valid index returns the full stored 64-bit entry on `op_rdata` with status 0, one cycle after the request.
- R7: A successful put pulses `ntf_valid` for one cycle together with `op_done`. The pulse carries:
  - iova = (aligned − offset) AND page mask;
  - paddr = data AND page mask;
  - the offset mask;
  - the permission bits.

  Gets and failed puts give no pulse.
- R8: An enable request is ignored while the entry count is nonzero. An enable request is also ignored when the requested count exceeds the table depth.
- R9: A disable request sets page shift, bus offset and entry count to zero, so every later lookup is out of range and every later put or get fails.
- R10: A clear pulse makes every entry read as zero. An accepted enable also starts from an all-zero table. A put in the same cycle as a clear is overridden by the clear, and `lk_ready` is low during a clear.
- R11: After reset the table is disabled and all response, done and notify outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_enable | input | 1 | 1 = enable with given parameters, 0 = disable |
| cfg_shift | input | 6 | Page shift (page size 2^shift) |
| cfg_offset | input | 64 | Bus offset subtracted by put/get |
| cfg_count | input | CNT_W | Number of entries in use |
| clr_req | input | 1 | Pulse clearing all entries |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_addr | input | 64 | Bus address to translate |
| lk_rsp_valid | output | 1 | Lookup result valid |
| lk_rsp_paddr | output | 64 | Translated page address |
| lk_rsp_iova | output | 64 | Page-aligned bus address |
| lk_rsp_mask | output | 64 | In-page offset mask |
| lk_rsp_perm | output | 2 | Permission code |
| op_valid | input | 1 | Put/get request |
| op_write | input | 1 | 1 = put, 0 = get |
| op_ioba | input | 64 | Bus address of the entry |
| op_data | input | 64 | Entry value for a put |
| op_done | output | 1 | Operation completed |
| op_status | output | 1 | 0 = success, 1 = parameter error |
| op_rdata | output | 64 | Entry returned by a get |
| ntf_valid | output | 1 | Invalidation notice |
| ntf_iova | output | 64 | Notified bus page |
| ntf_paddr | output | 64 | Notified physical page |
| ntf_mask | output | 64 | Notified offset mask |
| ntf_perm | output | 2 | Notified permission |

## Verification
Every result of this block is registered exactly once. The lookup response, the done/status/read data and the invalidation notice all appear on the first rising edge after the request is presented. The bench drives each request on a falling edge and removes it on the next falling edge. It reads the outputs at that second falling edge, which is half a cycle after they update. `lk_ready` is combinational on the clear pulse, so it is sampled a moment after the clear is driven. Effects of configuration and clear are checked through a later lookup or get, issued after the edge that applied them.

// File: rtl/dxt_pkg.sv
// Shared constants, the permission code type and the page-mask helper for
// the DMA translation table. Assumes 64-bit bus and physical addresses.
package dxt_pkg;

    localparam int ADDR_W  = 64;
    localparam int SHIFT_W = 6;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_WO   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    // Mask with the low 'sh' bits clear.
    function automatic logic [ADDR_W-1:0] page_mask(input logic [SHIFT_W-1:0] sh);
        return ~((ADDR_W'(1) << sh) - ADDR_W'(1));
    endfunction

endpackage

// File: rtl/dxt_cfg_regs.sv
// Holds the table geometry: page shift, bus offset and entry count.
// An enable is taken only while the count is zero and the requested count
// fits the table depth; a disable zeroes all three fields.
module dxt_cfg_regs
    import dxt_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_valid,
    input  logic               cfg_enable,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [ADDR_W-1:0]  cfg_offset,
    input  logic [CNT_W-1:0]   cfg_count,
    output logic [SHIFT_W-1:0] shift_q,
    output logic [ADDR_W-1:0]  offset_q,
    output logic [CNT_W-1:0]   count_q,
    output logic               fresh_en
);

    // Accept condition for an enable request.
    always_comb begin
        fresh_en = cfg_valid && cfg_enable && (count_q == '0)
                   && (cfg_count <= CNT_W'(DEPTH));
    end

    // Geometry registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q  <= '0;
            offset_q <= '0;
            count_q  <= '0;
        end else if (fresh_en) begin
            shift_q  <= cfg_shift;
            offset_q <= cfg_offset;
            count_q  <= cfg_count;
        end else if (cfg_valid && !cfg_enable) begin
            shift_q  <= '0;
            offset_q <= '0;
            count_q  <= '0;
        end
    end

endmodule

// File: rtl/dxt_entry_store.sv
// Entry RAM with a per-entry valid bit so the whole table can be wiped in
// one cycle. An entry whose valid bit is clear reads as zero (no access).
// One write port, two combinational read ports; clear overrides a write.
module dxt_entry_store
    import dxt_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [ADDR_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [ADDR_W-1:0] rd_b_data
);

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  vld;

    // Valid bits: cleared by reset or a wipe, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (clr_all) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    // Entry data storage, not reset.
    always_ff @(posedge clk) begin
        if (wr_en && !clr_all) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Read ports mask invalid entries to zero.
    always_comb begin
        rd_a_data = vld[rd_a_idx] ? mem[rd_a_idx] : '0;
        rd_b_data = vld[rd_b_idx] ? mem[rd_b_idx] : '0;
    end

endmodule

// File: rtl/dxt_lookup.sv
// Device-side translation: index = addr >> shift with no offset applied.
// Produces a registered result one cycle after an accepted request; an
// out-of-range index yields zero addresses, all-ones mask, no permission.
module dxt_lookup
    import dxt_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SHIFT_W-1:0] shift_q,
    input  logic [CNT_W-1:0]   count_q,
    output logic [IDX_W-1:0]   rd_idx,
    input  logic [ADDR_W-1:0]  rd_data,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic [ADDR_W-1:0]  rsp_iova,
    output logic [ADDR_W-1:0]  rsp_mask,
    output logic [1:0]         rsp_perm
);

    logic [ADDR_W-1:0] pm;
    logic [ADDR_W-1:0] idx_full;
    logic              in_range;

    // Index and range decode.
    always_comb begin
        pm       = page_mask(shift_q);
        idx_full = addr >> shift_q;
        in_range = idx_full < {{(ADDR_W-CNT_W){1'b0}}, count_q};
        rd_idx   = idx_full[IDX_W-1:0];
    end

    // Registered translation result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_iova  <= '0;
            rsp_mask  <= '0;
            rsp_perm  <= PERM_NONE;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                if (in_range) begin
                    rsp_paddr <= rd_data & pm;
                    rsp_iova  <= addr & pm;
                    rsp_mask  <= ~pm;
                    rsp_perm  <= rd_data[1:0];
                end else begin
                    rsp_paddr <= '0;
                    rsp_iova  <= '0;
                    rsp_mask  <= '1;
                    rsp_perm  <= PERM_NONE;
                end
            end
        end
    end

endmodule

// File: rtl/dxt_op_unit.sv
// Control-side put/get. Aligns the ioba to the page, subtracts the bus
// offset, and range-checks the index. A put writes the store and raises
// an invalidation notice; every request completes one cycle later.
module dxt_op_unit
    import dxt_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic               op_write,
    input  logic [ADDR_W-1:0]  op_ioba,
    input  logic [ADDR_W-1:0]  op_data,
    input  logic [SHIFT_W-1:0] shift_q,
    input  logic [ADDR_W-1:0]  offset_q,
    input  logic [CNT_W-1:0]   count_q,
    output logic [IDX_W-1:0]   idx,
    input  logic [ADDR_W-1:0]  rd_data,
    output logic               wr_en,
    output logic               done,
    output logic               status,
    output logic [ADDR_W-1:0]  rdata,
    output logic               ntf_valid,
    output logic [ADDR_W-1:0]  ntf_iova,
    output logic [ADDR_W-1:0]  ntf_paddr,
    output logic [ADDR_W-1:0]  ntf_mask,
    output logic [1:0]         ntf_perm
);

    logic [ADDR_W-1:0] pm;
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] idx_full;
    logic              hit;

    // Alignment, offset removal and range decode.
    always_comb begin
        pm       = page_mask(shift_q);
        rel      = (op_ioba & pm) - offset_q;
        idx_full = rel >> shift_q;
        hit      = idx_full < {{(ADDR_W-CNT_W){1'b0}}, count_q};
        idx      = idx_full[IDX_W-1:0];
        wr_en    = op_valid && op_write && hit;
    end

    // Completion, status and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            status <= 1'b0;
            rdata  <= '0;
        end else begin
            done   <= op_valid;
            status <= op_valid && !hit;
            rdata  <= (op_valid && !op_write && hit) ? rd_data : '0;
        end
    end

    // Invalidation notice for a successful put.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ntf_valid <= 1'b0;
            ntf_iova  <= '0;
            ntf_paddr <= '0;
            ntf_mask  <= '0;
            ntf_perm  <= PERM_NONE;
        end else begin
            ntf_valid <= wr_en;
            if (wr_en) begin
                ntf_iova  <= rel & pm;
                ntf_paddr <= op_data & pm;
                ntf_mask  <= ~pm;
                ntf_perm  <= op_data[1:0];
            end
        end
    end

endmodule

// File: rtl/dma_xlate_table.sv
// DMA page translation table top. Joins the geometry registers, entry
// store, lookup path and put/get unit. Assumes single-cycle requests on
// each port; a clear pulse blocks lookups for that cycle.
module dma_xlate_table
    import dxt_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_valid,
    input  logic               cfg_enable,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [ADDR_W-1:0]  cfg_offset,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic               clr_req,
    input  logic               lk_valid,
    output logic               lk_ready,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               lk_rsp_valid,
    output logic [ADDR_W-1:0]  lk_rsp_paddr,
    output logic [ADDR_W-1:0]  lk_rsp_iova,
    output logic [ADDR_W-1:0]  lk_rsp_mask,
    output logic [1:0]         lk_rsp_perm,
    input  logic               op_valid,
    input  logic               op_write,
    input  logic [ADDR_W-1:0]  op_ioba,
    input  logic [ADDR_W-1:0]  op_data,
    output logic               op_done,
    output logic               op_status,
    output logic [ADDR_W-1:0]  op_rdata,
    output logic               ntf_valid,
    output logic [ADDR_W-1:0]  ntf_iova,
    output logic [ADDR_W-1:0]  ntf_paddr,
    output logic [ADDR_W-1:0]  ntf_mask,
    output logic [1:0]         ntf_perm
);

    logic [SHIFT_W-1:0] shift_q;
    logic [ADDR_W-1:0]  offset_q;
    logic [CNT_W-1:0]   count_q;
    logic               fresh_en;
    logic [IDX_W-1:0]   lk_idx;
    logic [IDX_W-1:0]   op_idx;
    logic [ADDR_W-1:0]  lk_entry;
    logic [ADDR_W-1:0]  op_entry;
    logic               wr_en;
    logic               wipe;

    // Lookup gating and table wipe source.
    always_comb begin
        lk_ready = !clr_req;
        wipe     = clr_req || fresh_en;
    end

    dxt_cfg_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_enable(cfg_enable),
        .cfg_shift (cfg_shift),
        .cfg_offset(cfg_offset),
        .cfg_count (cfg_count),
        .shift_q   (shift_q),
        .offset_q  (offset_q),
        .count_q   (count_q),
        .fresh_en  (fresh_en)
    );

    dxt_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (wipe),
        .wr_en    (wr_en),
        .wr_idx   (op_idx),
        .wr_data  (op_data),
        .rd_a_idx (lk_idx),
        .rd_a_data(lk_entry),
        .rd_b_idx (op_idx),
        .rd_b_data(op_entry)
    );

    dxt_lookup #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) lk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (lk_valid && lk_ready),
        .addr     (lk_addr),
        .shift_q  (shift_q),
        .count_q  (count_q),
        .rd_idx   (lk_idx),
        .rd_data  (lk_entry),
        .rsp_valid(lk_rsp_valid),
        .rsp_paddr(lk_rsp_paddr),
        .rsp_iova (lk_rsp_iova),
        .rsp_mask (lk_rsp_mask),
        .rsp_perm (lk_rsp_perm)
    );

    dxt_op_unit #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) op_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_write (op_write),
        .op_ioba  (op_ioba),
        .op_data  (op_data),
        .shift_q  (shift_q),
        .offset_q (offset_q),
        .count_q  (count_q),
        .idx      (op_idx),
        .rd_data  (op_entry),
        .wr_en    (wr_en),
        .done     (op_done),
        .status   (op_status),
        .rdata    (op_rdata),
        .ntf_valid(ntf_valid),
        .ntf_iova (ntf_iova),
        .ntf_paddr(ntf_paddr),
        .ntf_mask (ntf_mask),
        .ntf_perm (ntf_perm)
    );

endmodule

// File: rtl/dxt_xlate_chk.sv
// Protocol and shape checks for the translation table, bound to the top.
module dxt_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clr_req,
    input logic        lk_valid,
    input logic        lk_ready,
    input logic        lk_rsp_valid,
    input logic [63:0] lk_rsp_paddr,
    input logic [63:0] lk_rsp_iova,
    input logic [63:0] lk_rsp_mask,
    input logic [1:0]  lk_rsp_perm,
    input logic        op_valid,
    input logic        op_write,
    input logic        op_done,
    input logic        op_status,
    input logic [63:0] op_rdata,
    input logic        ntf_valid
);

    // R2: an accepted lookup responds on the next cycle
    p_lk_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> lk_rsp_valid);

    // R2: the offset mask is a contiguous run of low ones
    p_lk_mask_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rsp_valid |-> (((lk_rsp_mask + 64'd1) & lk_rsp_mask) == 64'd0));

    // R2: returned addresses carry no in-page bits
    p_lk_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rsp_valid |-> (((lk_rsp_paddr & lk_rsp_mask) == 64'd0)
                          && ((lk_rsp_iova & lk_rsp_mask) == 64'd0)));

    // R3: an all-ones mask comes with no address and no permission
    p_oor_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rsp_valid && (lk_rsp_mask == '1)) |-> ((lk_rsp_paddr == 64'd0)
                         && (lk_rsp_iova == 64'd0) && (lk_rsp_perm == 2'd0)));

    // R4: every operation completes one cycle later
    p_op_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> op_done);

    // R5: a failed operation returns no data
    p_fail_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_status) |-> (op_rdata == 64'd0));

    // R7: a notice only accompanies a successful completion
    p_ntf_success_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> (op_done && !op_status));

    // R7: a get never raises a notice
    p_ntf_not_get_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_write) |=> !ntf_valid);

    // R10: a get right after a clear reads zero
    p_clear_get_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req ##1 (op_valid && !op_write) |=> (op_rdata == 64'd0));

endmodule

bind dma_xlate_table dxt_xlate_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_req     (clr_req),
    .lk_valid    (lk_valid),
    .lk_ready    (lk_ready),
    .lk_rsp_valid(lk_rsp_valid),
    .lk_rsp_paddr(lk_rsp_paddr),
    .lk_rsp_iova (lk_rsp_iova),
    .lk_rsp_mask (lk_rsp_mask),
    .lk_rsp_perm (lk_rsp_perm),
    .op_valid    (op_valid),
    .op_write    (op_write),
    .op_done     (op_done),
    .op_status   (op_status),
    .op_rdata    (op_rdata),
    .ntf_valid   (ntf_valid)
);

// File: tb/dma_xlate_table_tb.sv
module dma_xlate_table_tb_top;

    localparam int CLK_P = 10;
    localparam int DEPTH = 1024;
    localparam int CNT_W = $clog2(DEPTH + 1);

    // Vector kinds: 0 put, 1 get, 2 lookup. e_bad: 1 = error / out of range.
    typedef struct packed {
        logic [1:0]  kind;
        logic [63:0] addr;
        logic [63:0] data;
        logic        e_bad;
        logic [63:0] e_a;
        logic [63:0] e_b;
        logic [1:0]  e_perm;
    } vec_t;

    localparam int NV = 14;
    // Table set up with shift 12, offset 0x8000, 16 entries.
    localparam vec_t VECS [NV] = '{
        '{2'd0, 64'hB123,        64'h1_2345_6003, 1'b0, 64'h1_2345_6000, 64'h3000, 2'd3},
        '{2'd2, 64'h3ABC,        64'h0,           1'b0, 64'h1_2345_6000, 64'h3000, 2'd3},
        '{2'd1, 64'hB000,        64'h0,           1'b0, 64'h1_2345_6003, 64'h0,    2'd0},
        '{2'd0, 64'h8000,        64'hABCD_E001,   1'b0, 64'hABCD_E000,   64'h0,    2'd1},
        '{2'd2, 64'h0005,        64'h0,           1'b0, 64'hABCD_E000,   64'h0,    2'd1},
        '{2'd0, 64'h17FFF,       64'h5555_5002,   1'b0, 64'h5555_5000,   64'hF000, 2'd2},
        '{2'd2, 64'hFFFF,        64'h0,           1'b0, 64'h5555_5000,   64'hF000, 2'd2},
        '{2'd0, 64'h18000,       64'h7003,        1'b1, 64'h0,           64'h0,    2'd0},
        '{2'd2, 64'h10000,       64'h0,           1'b1, 64'h0,           64'h0,    2'd0},
        '{2'd1, 64'h18000,       64'h0,           1'b1, 64'h0,           64'h0,    2'd0},
        '{2'd0, 64'h7000,        64'h7003,        1'b1, 64'h0,           64'h0,    2'd0},
        '{2'd2, 64'h5010,        64'h0,           1'b0, 64'h0,           64'h5000, 2'd0},
        '{2'd1, 64'hD000,        64'h0,           1'b0, 64'h0,           64'h0,    2'd0},
        '{2'd1, 64'h8000,        64'h0,           1'b0, 64'hABCD_E001,   64'h0,    2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_valid = 1'b0, cfg_enable = 1'b0;
    logic [5:0] cfg_shift = '0;
    logic [63:0] cfg_offset = '0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic clr_req = 1'b0;
    logic lk_valid = 1'b0;
    logic lk_ready;
    logic [63:0] lk_addr = '0;
    logic lk_rsp_valid;
    logic [63:0] lk_rsp_paddr, lk_rsp_iova, lk_rsp_mask;
    logic [1:0] lk_rsp_perm;
    logic op_valid = 1'b0, op_write = 1'b0;
    logic [63:0] op_ioba = '0, op_data = '0;
    logic op_done, op_status;
    logic [63:0] op_rdata;
    logic ntf_valid;
    logic [63:0] ntf_iova, ntf_paddr, ntf_mask;
    logic [1:0] ntf_perm;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    dma_xlate_table #(.DEPTH(DEPTH)) dut_i (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic configure(input logic en, input logic [5:0] sh,
                             input logic [63:0] off, input logic [CNT_W-1:0] cnt);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_enable = en; cfg_shift = sh; cfg_offset = off; cfg_count = cnt;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [63:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic do_op(input logic w, input logic [63:0] a, input logic [63:0] d);
        @(negedge clk);
        op_valid = 1'b1; op_write = w; op_ioba = a; op_data = d;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic check_lookup(input string tag, input logic [63:0] pa, input logic [63:0] io,
                                input logic [63:0] mk, input logic [1:0] pr);
        check({tag, " valid"}, 64'(lk_rsp_valid), 64'd1);
        check({tag, " paddr"}, lk_rsp_paddr, pa);
        check({tag, " iova"},  lk_rsp_iova, io);
        check({tag, " mask"},  lk_rsp_mask, mk);
        check({tag, " perm"},  64'(lk_rsp_perm), 64'(pr));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 lk_rsp_valid", 64'(lk_rsp_valid), 64'd0);
        check("R11 op_done", 64'(op_done), 64'd0);
        check("R11 ntf_valid", 64'(ntf_valid), 64'd0);
        rst_n = 1'b1;
        // R11 / R3: disabled table after reset is out of range
        do_lookup(64'h0);
        check_lookup("R11 R3 disabled lookup", 64'h0, 64'h0, '1, 2'd0);

        configure(1'b1, 6'd12, 64'h8000, CNT_W'(16));

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            case (v.kind)
                2'd0: begin
                    do_op(1'b1, v.addr, v.data);
                    check($sformatf("R4 R5 put[%0d] status", i), 64'(op_status), 64'(v.e_bad));
                    check($sformatf("R7 put[%0d] notice", i), 64'(ntf_valid), 64'(!v.e_bad));
                    if (!v.e_bad) begin
                        check($sformatf("R7 put[%0d] paddr", i), ntf_paddr, v.e_a);
                        check($sformatf("R7 put[%0d] iova", i), ntf_iova, v.e_b);
                        check($sformatf("R7 put[%0d] mask", i), ntf_mask, 64'hFFF);
                        check($sformatf("R7 put[%0d] perm", i), 64'(ntf_perm), 64'(v.e_perm));
                    end
                end
                2'd1: begin
                    do_op(1'b0, v.addr, 64'h0);
                    check($sformatf("R6 R5 get[%0d] done", i), 64'(op_done), 64'd1);
                    check($sformatf("R6 R5 get[%0d] status", i), 64'(op_status), 64'(v.e_bad));
                    check($sformatf("R6 R5 get[%0d] rdata", i), op_rdata, v.e_a);
                    check($sformatf("R7 get[%0d] no notice", i), 64'(ntf_valid), 64'd0);
                end
                default: begin
                    do_lookup(v.addr);
                    check_lookup($sformatf("R1 R2 R3 lookup[%0d]", i), v.e_a, v.e_b,
                                 v.e_bad ? '1 : 64'hFFF, v.e_perm);
                end
            endcase
        end

        // R8: enable while enabled is ignored
        configure(1'b1, 6'd16, 64'h0, CNT_W'(4));
        do_lookup(64'h3ABC);
        check_lookup("R8 re-enable ignored", 64'h1_2345_6000, 64'h3000, 64'hFFF, 2'd3);

        // R10: clear pulse drops lookup ready and wipes entries
        @(negedge clk);
        clr_req = 1'b1;
        #1;
        check("R10 lk_ready during clear", 64'(lk_ready), 64'd0);
        @(negedge clk);
        clr_req = 1'b0;
        do_lookup(64'h3ABC);
        check_lookup("R10 after clear", 64'h0, 64'h3000, 64'hFFF, 2'd0);

        // R10: clear wins over a put in the same cycle
        @(negedge clk);
        clr_req = 1'b1; op_valid = 1'b1; op_write = 1'b1; op_ioba = 64'hA000; op_data = 64'h9003;
        @(negedge clk);
        clr_req = 1'b0; op_valid = 1'b0;
        do_op(1'b0, 64'hA000, 64'h0);
        check("R10 clear beats put", op_rdata, 64'h0);

        // R9: disable makes everything out of range
        configure(1'b0, 6'd0, 64'h0, '0);
        do_op(1'b0, 64'h8000, 64'h0);
        check("R9 get after disable", 64'(op_status), 64'd1);
        do_lookup(64'h0);
        check_lookup("R9 lookup after disable", 64'h0, 64'h0, '1, 2'd0);

        // R8: oversize count refused
        configure(1'b1, 6'd12, 64'h0, CNT_W'(DEPTH + 1));
        do_lookup(64'h0);
        check_lookup("R8 oversize enable", 64'h0, 64'h0, '1, 2'd0);

        // R2 with a larger page, then R10 fresh enable starts empty
        configure(1'b1, 6'd16, 64'h0, CNT_W'(2));
        do_op(1'b1, 64'h12345, 64'h7777_0003);
        check("R4 put shift16", 64'(op_status), 64'd0);
        do_lookup(64'h1FFFF);
        check_lookup("R2 shift16", 64'h7777_0000, 64'h10000, 64'hFFFF, 2'd3);
        configure(1'b0, 6'd0, 64'h0, '0);
        configure(1'b1, 6'd16, 64'h0, CNT_W'(2));
        do_lookup(64'h1FFFF);
        check_lookup("R10 fresh enable", 64'h0, 64'h10000, 64'hFFFF, 2'd0);

        finish_run();
    end

endmodule